// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a bank of sixteen byte-wide registers that sit behind a slower internal port. The host sees three byte registers, picked by a 2-bit select: a key register, an address/control register and a data register. The interface starts out locked. It opens only after the key register receives 0xA5 and then 0xF1.

Once the interface is open, the host chooses an internal register through the control register. Writing the data register pushes a byte into that internal register. Setting the busy bit in the control register fetches the internal register into the data register. Every transfer takes a fixed number of cycles, and busy stays high during that time. This fixed delay stands in for the crossing into the other clock domain.

When a transfer ends, the internal address steps by one and wraps at the top of the bank. Repeated data accesses therefore walk consecutive registers. When auto-read is enabled, each host read of the data register returns the byte that was already fetched and at the same time launches the fetch of the next register. Bank slots 0-5 hold the capture bytes, 6 is control, 7 is oscillator control, 8-13 hold the alarm bytes, 14 is the RAM address and 15 is the RAM data. The bridge treats all sixteen slots the same way.

Top module: `ireg_bridge`

## Requirements
- R1: After reset the interface is locked and busy is 0. Reads of the key register (select 0), the control register (select 1), the data register (select 2) and select 3 all return 0x00.
- R2: The interface unlocks only after the key register is written 0xA5 and then 0xF1. While the interface is locked, writes to the control and data registers have no effect.
- R3: A key write other than the expected next byte returns the lock to its initial state. A 0xA5 always restarts the sequence, and any other byte written after unlock locks the interface again.
- R4: The control register reads as {busy[7], autoread[6], 0[5], short_mode[4], addr[3:0]}. The short_mode bit is stored and read back but has no effect on transfers.
- R5: Writing the control register with bit 7 set starts a read of the addressed register. Busy reads 1 for exactly LATENCY (3) cycles, and after that the data register holds the bank value.
- R6: A write of the data register while unlocked and idle starts a write of that byte to the addressed register. The write lasts LATENCY cycles with busy high.
- R7: Each completed transfer increments the internal address, and the address wraps from 15 to 0.
- R8: With autoread set, a host read of the data register while idle returns the current byte and starts a read of the current (already incremented) address. With autoread clear, a data read starts nothing.
- R9: Control or data writes made while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the selected register |
| host_rd | input | 1 | Host read strobe for the selected register |
| host_sel | input | 2 | Register select: 0 key, 1 control, 2 data, 3 unused |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Selected register contents (combinational) |

## Verification
The bench sends a broken key sequence (0xA5, 0x00, 0xF1) and a repeated 0xA5 before 0xF1. A lock that only tracked the last byte would open on the first sequence, and a lock with no restart would stay shut on the second. It writes the data and control registers in the middle of a transfer. A design that failed to block those writes would either corrupt the slot at the next address or move the pointer. It runs a six-byte write burst, an auto-read burst and a transfer at address 15. A design that got these wrong would return bytes out of order, fetch the same slot twice, or fail to wrap the pointer to 0. It also counts the busy cycles one by one, so a counter that is off by one shows up as an early or late clear.

// File: rtl/ireg_pkg.sv
// Shared constants and types for the indirect register bridge.
// Assumes an 8-bit host bus and a 4-bit internal address.
package ireg_pkg;

    typedef enum logic [1:0] {
        HSEL_KEY  = 2'd0,
        HSEL_CTL  = 2'd1,
        HSEL_DATA = 2'd2,
        HSEL_NONE = 2'd3
    } hsel_e;

    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_HALF  = 2'd1,
        LK_OPEN  = 2'd2
    } lock_e;

    localparam logic [7:0] KEY_BYTE_A = 8'hA5;
    localparam logic [7:0] KEY_BYTE_B = 8'hF1;

    localparam int CTL_BUSY_BIT  = 7;
    localparam int CTL_AUTO_BIT  = 6;
    localparam int CTL_SHORT_BIT = 4;

endpackage

// File: rtl/ireg_key_lock.sv
// Key-sequence lock. Opens after the two key bytes arrive in order.
// Any byte that breaks the sequence returns to idle; the first key byte
// always restarts the sequence. Assumes one key write per strobe.
module ireg_key_lock
    import ireg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we,
    input  logic [7:0] key_byte,
    output logic       unlocked_o
);

    lock_e state_q, state_d;

    // Next-state rule for each key write.
    always_comb begin
        state_d = state_q;
        if (key_we) begin
            if (key_byte == KEY_BYTE_A)
                state_d = LK_HALF;
            else if (state_q == LK_HALF && key_byte == KEY_BYTE_B)
                state_d = LK_OPEN;
            else
                state_d = LK_IDLE;
        end
    end

    // Lock state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    assign unlocked_o = (state_q == LK_OPEN);

    // R3: a byte that is neither key byte always relocks.
    a_r3_bad_byte_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        key_we && key_byte != KEY_BYTE_A && key_byte != KEY_BYTE_B |=> !unlocked_o);

    // R2: opening requires the second key byte on the previous cycle.
    a_r2_open_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked_o) |-> $past(key_we) && $past(key_byte) == KEY_BYTE_B);

endmodule

// File: rtl/ireg_bank.sv
// Internal register bank behind a simple port: one write per cycle,
// combinational read of the addressed slot. Cleared on reset.
module ireg_bank #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Storage update: clear on reset, otherwise single-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    // R6: a write lands in the addressed slot.
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(addr)] == $past(wdata));

endmodule

// File: rtl/ireg_xfer_ctrl.sv
// Transfer engine: holds the control fields, the data byte and the
// latency counter. A transfer completes LAT cycles after launch, then
// the address steps by one. Assumes AW = 4 for the control byte layout.
module ireg_xfer_ctrl
    import ireg_pkg::*;
#(
    parameter int DW  = 8,
    parameter int AW  = 4,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          unlock_i,
    input  logic          ctl_we,
    input  logic          data_we,
    input  logic          data_re,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] bank_rdata_i,
    output logic [DW-1:0] ctl_rd_o,
    output logic [DW-1:0] data_rd_o,
    output logic          bank_we_o,
    output logic [AW-1:0] bank_addr_o,
    output logic [DW-1:0] bank_wdata_o
);

    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(LAT - 1);

    logic          busy_q, wr_q, auto_q, short_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [CW-1:0] cnt_q;
    logic          done;
    logic          idle_ok;

    assign done    = busy_q && (cnt_q == '0);
    assign idle_ok = !busy_q && unlock_i;

    // Launch, count down and complete transfers; latch host fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            wr_q    <= 1'b0;
            auto_q  <= 1'b0;
            short_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            cnt_q   <= '0;
        end else if (busy_q) begin
            if (done) begin
                busy_q <= 1'b0;
                addr_q <= addr_q + AW'(1);
                if (!wr_q) data_q <= bank_rdata_i;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end else if (idle_ok) begin
            if (ctl_we) begin
                auto_q  <= wdata[CTL_AUTO_BIT];
                short_q <= wdata[CTL_SHORT_BIT];
                addr_q  <= wdata[AW-1:0];
                if (wdata[CTL_BUSY_BIT]) begin
                    busy_q <= 1'b1;
                    wr_q   <= 1'b0;
                    cnt_q  <= CNT_LOAD;
                end
            end else if (data_we) begin
                data_q <= wdata;
                busy_q <= 1'b1;
                wr_q   <= 1'b1;
                cnt_q  <= CNT_LOAD;
            end else if (data_re && auto_q) begin
                busy_q <= 1'b1;
                wr_q   <= 1'b0;
                cnt_q  <= CNT_LOAD;
            end
        end
    end

    assign ctl_rd_o     = {busy_q, auto_q, 1'b0, short_q, addr_q};
    assign data_rd_o    = data_q;
    assign bank_we_o    = done && wr_q;
    assign bank_addr_o  = addr_q;
    assign bank_wdata_o = data_q;

    // R2: nothing launches while locked.
    a_r2_locked_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock_i && !busy_q |=> !busy_q);

    // R5: busy holds until the counter runs out.
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && cnt_q != '0 |=> busy_q);

    // R7: completion steps the address by one with wrap.
    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> addr_q == $past(addr_q) + AW'(1));

    // R9: control fields and address frozen mid-transfer.
    a_r9_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !done |=> $stable(addr_q) && $stable(auto_q) && $stable(short_q));

endmodule

// File: rtl/ireg_bridge.sv
// Top of the indirect register bridge: decodes host strobes onto the
// key lock, transfer engine and register bank, and muxes read data.
// Assumes host strobes are single-cycle and synchronous to clk.
module ireg_bridge
    import ireg_pkg::*;
#(
    parameter int DW  = 8,
    parameter int AW  = 4,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [1:0]    host_sel,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);

    logic          key_we, ctl_we, data_we, data_re;
    logic          unlocked;
    logic [DW-1:0] ctl_rd, data_rd, bank_rdata, bank_wdata;
    logic          bank_we;
    logic [AW-1:0] bank_addr;

    assign key_we  = host_wr && (host_sel == HSEL_KEY);
    assign ctl_we  = host_wr && (host_sel == HSEL_CTL);
    assign data_we = host_wr && (host_sel == HSEL_DATA);
    assign data_re = host_rd && (host_sel == HSEL_DATA);

    ireg_key_lock u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_we     (key_we),
        .key_byte   (host_wdata),
        .unlocked_o (unlocked)
    );

    ireg_xfer_ctrl #(.DW(DW), .AW(AW), .LAT(LAT)) u_xfer (
        .clk          (clk),
        .rst_n        (rst_n),
        .unlock_i     (unlocked),
        .ctl_we       (ctl_we),
        .data_we      (data_we),
        .data_re      (data_re),
        .wdata        (host_wdata),
        .bank_rdata_i (bank_rdata),
        .ctl_rd_o     (ctl_rd),
        .data_rd_o    (data_rd),
        .bank_we_o    (bank_we),
        .bank_addr_o  (bank_addr),
        .bank_wdata_o (bank_wdata)
    );

    ireg_bank #(.DW(DW), .AW(AW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .addr  (bank_addr),
        .wdata (bank_wdata),
        .rdata (bank_rdata)
    );

    // Host read mux by select.
    always_comb begin
        case (host_sel)
            HSEL_CTL:  host_rdata = ctl_rd;
            HSEL_DATA: host_rdata = data_rd;
            default:   host_rdata = '0;
        endcase
    end

    // R6: bank writes only happen after the interface was opened.
    a_r6_write_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> $past(unlocked) || unlocked);

endmodule

// File: tb/ireg_bridge_tb.sv
module ireg_bridge_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } sb_item_t;

    sb_item_t sbq[$];

    always #10 clk = ~clk;

    ireg_bridge u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, input logic [7:0] e, input string req);
        sb_item_t it;
        it.exp = e; it.req = req;
        host_sel = s; host_rd = 1'b1;
        sbq.push_back(it);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected items and compares each host read.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (host_rd) begin
                sb_item_t it;
                vectors++;
                if (sbq.size() == 0) begin
                    miscompares++;
                    $display("FAIL scoreboard: read with no expected item, got %02h", host_rdata);
                end else begin
                    it = sbq.pop_front();
                    if (host_rdata !== it.exp) begin
                        miscompares++;
                        $display("FAIL %s: got %02h expected %02h", it.req, host_rdata, it.exp);
                    end
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done_flag) begin
            miscompares++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, 8'h00, "R1 key");
        rd(2'd1, 8'h00, "R1 ctl");
        rd(2'd2, 8'h00, "R1 data");
        rd(2'd3, 8'h00, "R1 sel3");
        // R2 locked writes ignored
        wr(2'd1, 8'h93);
        rd(2'd1, 8'h00, "R2 locked ctl");
        wr(2'd2, 8'h55);
        idle(4);
        rd(2'd1, 8'h00, "R2 locked data no busy");
        // R3 broken sequence stays locked
        wr(2'd0, 8'hA5); wr(2'd0, 8'h00); wr(2'd0, 8'hF1);
        wr(2'd1, 8'h12);
        rd(2'd1, 8'h00, "R3 broken seq");
        // R3 repeated first byte restarts, then R2 unlock
        wr(2'd0, 8'hA5); wr(2'd0, 8'hA5); wr(2'd0, 8'hF1);
        wr(2'd1, 8'h12);
        rd(2'd1, 8'h12, "R2 unlocked ctl");
        // R4 field layout
        wr(2'd1, 8'h7A);
        rd(2'd1, 8'h5A, "R4 fields");
        wr(2'd1, 8'h14);
        rd(2'd1, 8'h14, "R4 fields clear");
        // R6 write with R5 busy length
        wr(2'd2, 8'hC3);
        rd(2'd1, 8'h94, "R5 busy c1");
        rd(2'd1, 8'h94, "R5 busy c2");
        rd(2'd1, 8'h94, "R5 busy c3");
        rd(2'd1, 8'h15, "R7 step after R6 write");
        // R9 writes while busy ignored
        wr(2'd1, 8'h10);
        wr(2'd2, 8'h11);
        wr(2'd2, 8'h99);
        wr(2'd1, 8'h1F);
        idle(1);
        rd(2'd1, 8'h11, "R9 ctl unchanged");
        wr(2'd1, 8'h90); idle(3);
        rd(2'd2, 8'h11, "R5 read back");
        wr(2'd1, 8'h91); idle(3);
        rd(2'd2, 8'h00, "R9 no stray write");
        // R7 six-byte write burst
        wr(2'd1, 8'h10);
        for (int i = 0; i < 6; i++) begin
            wr(2'd2, 8'hA0 + 8'(i));
            idle(3);
        end
        rd(2'd1, 8'h16, "R7 burst end");
        // R8 auto-read burst
        wr(2'd1, 8'hD0); idle(3);
        for (int i = 0; i < 6; i++) begin
            rd(2'd2, 8'hA0 + 8'(i), "R8 autoread");
            idle(3);
        end
        // R7 wrap
        wr(2'd1, 8'h1F);
        wr(2'd2, 8'h3C); idle(3);
        rd(2'd1, 8'h10, "R7 wrap");
        wr(2'd1, 8'h9F); idle(3);
        rd(2'd2, 8'h3C, "R6 slot15");
        rd(2'd1, 8'h10, "R7 wrap read");
        // R4 short bit clear works; R8 no launch without autoread
        wr(2'd1, 8'h0E);
        wr(2'd2, 8'h5A); idle(3);
        wr(2'd1, 8'h8E); idle(3);
        rd(2'd2, 8'h5A, "R4 short off");
        rd(2'd1, 8'h0F, "R8 no autoread launch");
        // R3 relock after open
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h13);
        rd(2'd1, 8'h0F, "R3 relock ctl");
        wr(2'd2, 8'h77); idle(4);
        rd(2'd1, 8'h0F, "R3 relock data");
        idle(2);
        if (sbq.size() != 0) begin
            miscompares++;
            $display("FAIL scoreboard: got %0d left expected 0", sbq.size());
        end
        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule